// File: doc/BRIEF.md
# Memory Boundary-Scan Test Access Port

This block is the serial test port of a memory device. A host drives four serial signals, a mode-select line, a data-in line, a data-out line and a test clock, plus an optional active-low asynchronous reset. Through them it walks a sixteen-state controller and loads a 3-bit instruction. The instruction chooses which data register sits between the serial input and output. The choices are a one-bit pass-through register, a 32-bit identity word, or a 107-cell boundary chain that samples the device pins in parallel and can hold values to drive onto them.

One instruction captures the pins and also forces every memory output driver into high impedance for as long as it stays loaded. The output-disable line shows this. Two other instructions let the captured or shifted boundary contents reach the pin-drive latches on Update-DR. The memory array and the pad cells are not part of this block.

Top module: `sram_tap`

## Requirements
- R1: After reset, with no instruction loaded, a 32-bit Shift-DR returns the identity word least significant bit first. Bit 0 is 1. Bits 11:1 are vendor code 11'b00000110100. Bits 28:12 are device code 17'h1A895. Bits 31:29 are revision 3'b000.
- R2: In Capture-IR the instruction shift register loads 3'b001. During the following Shift-IR the bits leave in the order 1, 0, 0. Instruction bits are shifted in least significant bit first.
- R3: Opcode 3'b111 selects the one-bit pass-through register. It captures 0, so the serial output is a 0 followed by the input stream delayed by one bit.
- R4: The unused opcodes 3'b011, 3'b101 and 3'b110 behave exactly like 3'b111. They leave the output disable low.
- R5: Opcode 3'b100 captures pin_in into the 107-cell chain. Cell 0 leaves first. On Update-DR the shifted chain contents load pin_out. drv_hiz stays low.
- R6: Opcode 3'b010 holds drv_hiz high while it is the active instruction. It captures pin_in into the chain. Update-DR under this opcode leaves pin_out unchanged.
- R7: Opcode 3'b000 captures pin_in into the chain. Update-DR loads pin_out from the chain.
- R8: tdo_oe is high only while the controller is in Shift-IR or Shift-DR. tdo and tdo_oe change on the falling edge of tck.
- R9: Five consecutive tck cycles with tms high reach Test-Logic-Reset from any state. There the instruction becomes 3'b001 (identity), and drv_hiz returns low.
- R10: trst_n low resets the block at once, without a clock. It clears tdo_oe, drv_hiz and pin_out, and selects the identity instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in, sampled on rising tck |
| tdo | output | 1 | Serial data out, updated on falling tck |
| tdo_oe | output | 1 | High while tdo carries shifted data |
| pin_in | input | BSR_LEN | Parallel capture from the device pins |
| pin_out | output | BSR_LEN | Boundary update latches driving the pins |
| drv_hiz | output | 1 | Forces memory output drivers to high impedance |

## Verification
The bound checker watches four things on every rising tck edge. It checks that tdo_oe matches the shift states, and that Capture-IR and Test-Logic-Reset load their fixed patterns. It checks that pin_out moves only on an Update-DR that the active opcode allows, and that drv_hiz rises only after Update-IR. The directed scenarios cover what no single-cycle property can show. These are the bit order and content of the identity word, the one-bit delay through the pass-through path, the treatment of the unused opcodes, the capture of pin patterns into the boundary chain, and the return to the identity instruction after five tms-high cycles.

// File: rtl/sram_tap.sv
module sram_tap #(
  parameter int          BSR_LEN  = 107,
  parameter logic [2:0]  REV      = 3'b000,
  parameter logic [16:0] DEV_CODE = 17'h1A895,
  parameter logic [10:0] VENDOR   = 11'b00000110100
) (
  input  logic               tck,
  input  logic               trst_n,
  input  logic               tms,
  input  logic               tdi,
  output logic               tdo,
  output logic               tdo_oe,
  input  logic [BSR_LEN-1:0] pin_in,
  output logic [BSR_LEN-1:0] pin_out,
  output logic               drv_hiz
);
  localparam logic [31:0] ID_WORD = {REV, DEV_CODE, VENDOR, 1'b1};
  localparam logic [2:0] OP_EXTEST = 3'b000;
  localparam logic [2:0] OP_IDENT  = 3'b001;
  localparam logic [2:0] OP_SAMPZ  = 3'b010;
  localparam logic [2:0] OP_PRELD  = 3'b100;

  typedef enum logic [3:0] {
    TLR = 4'd0, RTI = 4'd1, SEL_DR = 4'd2, CAP_DR = 4'd3,
    SH_DR = 4'd4, EX1_DR = 4'd5, PA_DR = 4'd6, EX2_DR = 4'd7,
    UP_DR = 4'd8, SEL_IR = 4'd9, CAP_IR = 4'd10, SH_IR = 4'd11,
    EX1_IR = 4'd12, PA_IR = 4'd13, EX2_IR = 4'd14, UP_IR = 4'd15
  } tap_st_e;

  tap_st_e             state, nxt;
  logic [2:0]          ir, ir_sh;
  logic                byp;
  logic [31:0]         id_sh;
  logic [BSR_LEN-1:0]  bsr;
  logic                sel_bsr, sel_id, serial;

  always_comb begin
    case (state)
      TLR:    nxt = tms ? TLR    : RTI;
      RTI:    nxt = tms ? SEL_DR : RTI;
      SEL_DR: nxt = tms ? SEL_IR : CAP_DR;
      CAP_DR: nxt = tms ? EX1_DR : SH_DR;
      SH_DR:  nxt = tms ? EX1_DR : SH_DR;
      EX1_DR: nxt = tms ? UP_DR  : PA_DR;
      PA_DR:  nxt = tms ? EX2_DR : PA_DR;
      EX2_DR: nxt = tms ? UP_DR  : SH_DR;
      UP_DR:  nxt = tms ? SEL_DR : RTI;
      SEL_IR: nxt = tms ? TLR    : CAP_IR;
      CAP_IR: nxt = tms ? EX1_IR : SH_IR;
      SH_IR:  nxt = tms ? EX1_IR : SH_IR;
      EX1_IR: nxt = tms ? UP_IR  : PA_IR;
      PA_IR:  nxt = tms ? EX2_IR : PA_IR;
      EX2_IR: nxt = tms ? UP_IR  : SH_IR;
      default: nxt = tms ? SEL_DR : RTI;
    endcase
  end

  assign sel_bsr = (ir == OP_EXTEST) || (ir == OP_SAMPZ) || (ir == OP_PRELD);
  assign sel_id  = (ir == OP_IDENT);
  assign drv_hiz = (ir == OP_SAMPZ);
  assign serial  = (state == SH_IR) ? ir_sh[0] :
                   sel_bsr ? bsr[0] : sel_id ? id_sh[0] : byp;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      state   <= TLR;
      ir      <= OP_IDENT;
      ir_sh   <= '0;
      byp     <= 1'b0;
      id_sh   <= '0;
      bsr     <= '0;
      pin_out <= '0;
    end else begin
      state <= nxt;
      case (state)
        TLR:    ir    <= OP_IDENT;
        CAP_IR: ir_sh <= 3'b001;
        SH_IR:  ir_sh <= {tdi, ir_sh[2:1]};
        UP_IR:  ir    <= ir_sh;
        CAP_DR: begin
          if (sel_bsr)     bsr   <= pin_in;
          else if (sel_id) id_sh <= ID_WORD;
          else             byp   <= 1'b0;
        end
        SH_DR: begin
          if (sel_bsr)     bsr   <= {tdi, bsr[BSR_LEN-1:1]};
          else if (sel_id) id_sh <= {tdi, id_sh[31:1]};
          else             byp   <= tdi;
        end
        UP_DR:
          if (ir == OP_EXTEST || ir == OP_PRELD) pin_out <= bsr;
        default: ;
      endcase
    end
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= serial;
      tdo_oe <= (state == SH_IR) || (state == SH_DR);
    end
  end
endmodule

// File: rtl/sram_tap_chk.sv
module sram_tap_chk #(
  parameter int N = 107
) (
  input logic         tck,
  input logic         trst_n,
  input logic         tdo_oe,
  input logic         drv_hiz,
  input logic [3:0]   st,
  input logic [2:0]   ir,
  input logic [2:0]   ir_sh,
  input logic [N-1:0] pin_out
);
  localparam logic [3:0] S_TLR = 4'd0, S_SH_DR = 4'd4, S_UP_DR = 4'd8;
  localparam logic [3:0] S_CAP_IR = 4'd10, S_SH_IR = 4'd11, S_UP_IR = 4'd15;

  // R8
  oe_shift_only_chk: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe == (st == S_SH_IR || st == S_SH_DR));
  // R2
  capir_pattern_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (st == S_CAP_IR) |=> (ir_sh == 3'b001));
  // R9
  tlr_ident_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (st == S_TLR) |=> (ir == 3'b001 && !drv_hiz));
  // R6
  hiz_rise_chk: assert property (@(posedge tck) disable iff (!trst_n)
    $rose(drv_hiz) |-> ($past(st) == S_UP_IR));
  // R5
  pin_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (st != S_UP_DR) |=> $stable(pin_out));
  // R6
  sampz_noupd_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (st == S_UP_DR && ir == 3'b010) |=> $stable(pin_out));
endmodule

bind sram_tap sram_tap_chk #(.N(BSR_LEN)) u_chk (
  .tck(tck), .trst_n(trst_n), .tdo_oe(tdo_oe), .drv_hiz(drv_hiz),
  .st(state), .ir(ir), .ir_sh(ir_sh), .pin_out(pin_out)
);

// File: tb/sram_tap_tb.sv
`timescale 1ns/1ps
module sram_tap_tb;
  localparam int N = 107;
  localparam logic [31:0] EXP_ID = {3'b000, 17'h1A895, 11'b00000110100, 1'b1};

  logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic tdo, tdo_oe, drv_hiz;
  logic [N-1:0] pin_in = '0, pin_out;
  int n_chk = 0, n_fail = 0;
  logic finished = 1'b0;

  always #2.5 tck = ~tck;

  sram_tap u_dut (.tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
    .tdo_oe(tdo_oe), .pin_in(pin_in), .pin_out(pin_out), .drv_hiz(drv_hiz));

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] mkpat(input int seed);
    logic [N-1:0] p;
    for (int i = 0; i < N; i++) p[i] = ((i * seed + seed / 2) % 3) == 0;
    return p;
  endfunction

  task automatic step(input logic m, input logic d);
    @(negedge tck); #1; tms = m; tdi = d; @(posedge tck); #1;
  endtask

  task automatic scan(input int n, input logic [127:0] din, output logic [127:0] dout, output logic oe);
    dout = '0; oe = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge tck); #1;
      dout[i] = tdo;
      if (i == 0) oe = tdo_oe;
      tms = (i == n - 1); tdi = din[i];
      @(posedge tck);
    end
  endtask

  task automatic load_ir(input logic [2:0] code, output logic [2:0] cap);
    logic [127:0] o; logic oe;
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    scan(3, {125'b0, code}, o, oe);
    step(1, 0); step(0, 0);
    cap = o[2:0];
  endtask

  task automatic shift_dr(input int n, input logic [127:0] din, output logic [127:0] dout, output logic oe);
    step(1, 0); step(0, 0); step(0, 0);
    scan(n, din, dout, oe);
    step(1, 0); step(0, 0);
  endtask

  task automatic t_reset;
    logic [127:0] o; logic oe;
    trst_n = 1'b0; #3;
    // R10
    chk(tdo_oe == 0 && drv_hiz == 0 && pin_out == '0, "R10 reset outputs",
        {tdo_oe, drv_hiz, pin_out != '0}, 0);
    #10; trst_n = 1'b1;
    step(0, 0);
    // R1
    shift_dr(32, 128'h0, o, oe);
    chk(o[31:0] == EXP_ID, "R1 identity word", o[31:0], EXP_ID);
    // R8
    chk(oe == 1'b1, "R8 tdo_oe in Shift-DR", oe, 1);
    chk(tdo_oe == 1'b0, "R8 tdo_oe in Run-Test/Idle", tdo_oe, 0);
  endtask

  task automatic t_ir_capture;
    logic [2:0] c;
    load_ir(3'b111, c);
    // R2
    chk(c == 3'b001, "R2 Capture-IR pattern", c, 3'b001);
  endtask

  task automatic t_bypass(input logic [2:0] code, input string tag);
    logic [2:0] c; logic [127:0] o; logic oe;
    logic [127:0] d = 128'hB2;
    load_ir(code, c);
    shift_dr(8, d, o, oe);
    chk(o[7:0] == {d[6:0], 1'b0}, tag, o[7:0], {d[6:0], 1'b0});
    chk(drv_hiz == 1'b0, tag, drv_hiz, 0);
  endtask

  task automatic t_preload;
    logic [2:0] c; logic [127:0] o; logic oe;
    logic [N-1:0] a = mkpat(5), b = mkpat(7);
    pin_in = a;
    load_ir(3'b100, c);
    chk(drv_hiz == 1'b0, "R5 drv_hiz low", drv_hiz, 0);
    shift_dr(N, {21'b0, b}, o, oe);
    // R5
    chk(o[N-1:0] == a, "R5 capture of pins", o[N-1:0], a);
    chk(pin_out == b, "R5 update to pins", pin_out, b);
  endtask

  task automatic t_sampz;
    logic [2:0] c; logic [127:0] o; logic oe;
    logic [N-1:0] keep = pin_out, a = mkpat(11), b = mkpat(4);
    pin_in = a;
    load_ir(3'b010, c);
    // R6
    chk(drv_hiz == 1'b1, "R6 drv_hiz high", drv_hiz, 1);
    shift_dr(N, {21'b0, b}, o, oe);
    chk(o[N-1:0] == a, "R6 capture of pins", o[N-1:0], a);
    chk(pin_out == keep, "R6 pin_out untouched", pin_out, keep);
    chk(drv_hiz == 1'b1, "R6 drv_hiz held", drv_hiz, 1);
  endtask

  task automatic t_tlr;
    logic [127:0] o; logic oe;
    for (int i = 0; i < 5; i++) step(1, 0);
    // R9
    chk(drv_hiz == 1'b0, "R9 drv_hiz after reset walk", drv_hiz, 0);
    step(0, 0);
    shift_dr(32, 128'h0, o, oe);
    chk(o[31:0] == EXP_ID, "R9 identity after reset walk", o[31:0], EXP_ID);
  endtask

  task automatic t_extest;
    logic [2:0] c; logic [127:0] o; logic oe;
    logic [N-1:0] a = mkpat(13), b = ~mkpat(2);
    pin_in = a;
    load_ir(3'b000, c);
    shift_dr(N, {21'b0, b}, o, oe);
    // R7
    chk(o[N-1:0] == a, "R7 capture of pins", o[N-1:0], a);
    chk(pin_out == b, "R7 update to pins", pin_out, b);
  endtask

  initial begin
    t_reset();
    t_ir_capture();
    t_bypass(3'b111, "R3 pass-through delay");
    t_bypass(3'b011, "R4 unused opcode 011");
    t_bypass(3'b101, "R4 unused opcode 101");
    t_bypass(3'b110, "R4 unused opcode 110");
    t_preload();
    t_sampz();
    t_tlr();
    t_extest();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule